// File: doc/BRIEF.md
# Transmit Gather Engine With Ring-Wrapped Payload Fetch

This block turns a stream of transmit descriptors into a byte-wide symbol stream for a line encoder. Each descriptor carries a fixed-size header, the start address of a payload in memory, the payload length in bytes, and the base-2 exponent of the size of the source ring that holds the payload. The engine first sends a header marker, then the header bytes, then a payload marker, and then the payload. It fetches the payload one byte at a time through a simple read port.

Source rings are aligned on their own power-of-two size. Payload reads therefore keep the upper address bits fixed and count only the low bits, which wrap inside the ring. The output line never goes quiet. When there is no descriptor to send, or when memory cannot deliver the next payload byte, the engine sends a filler control symbol.

A descriptor whose payload would not fit inside its own ring is consumed without sending anything, and an error pulse is raised.

Top module: `tx_gather`

## Requirements
- R1: After reset, and whenever no frame is in progress, the output is the filler symbol: out_ctrl = 1 and out_data = 8'h1C. While the engine is idle, desc_ready is 1 and rd_req is 0.
- R2: Each accepted descriptor produces symbols in this order:
  - a header marker (out_ctrl = 1, out_data = 8'h3C);
  - the HB header bytes with out_ctrl = 0, least significant byte of desc_hdr first;
  - a payload marker (out_ctrl = 1, out_data = 8'h5C);
  - desc_len payload bytes with out_ctrl = 0.
- R3: Payload byte i is read from address (A & ~M) | ((A + i) & M), where A is desc_addr and M = 2^k - 1 for ring exponent k. When k >= AW, the mask M covers the whole address space.
- R4: When rd_req is high and rd_ready is low, the engine emits the filler symbol for that cycle and keeps rd_addr unchanged. Every payload byte is sent exactly once, in order.
- R5: When out_ready is low, rd_req is low and the engine does not advance. Outside the idle and payload states, the presented symbol stays unchanged.
- R6: desc_ready is high only when the engine is idle or in the cycle that transfers the final payload byte. A descriptor accepted in that final cycle starts its header marker in the very next symbol, with no filler in between.
- R7: A descriptor with desc_len = 0 produces the header marker, the header bytes and the payload marker, then returns to filler.
- R8: A descriptor with desc_len > 2^k is consumed, produces no symbols, and makes desc_err high for exactly the one cycle after it is accepted. A descriptor with desc_len = 2^k is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| desc_valid | input | 1 | A descriptor is offered |
| desc_ready | output | 1 | The engine takes the offered descriptor at this edge |
| desc_hdr | input | HB*8 | Header bytes, least significant byte sent first |
| desc_addr | input | AW | Byte address of the first payload byte |
| desc_len | input | LW | Payload length in bytes |
| desc_ring_log2 | input | EW | Base-2 exponent of the source ring size |
| desc_err | output | 1 | One-cycle pulse after a descriptor is rejected |
| rd_req | output | 1 | A payload byte is requested this cycle |
| rd_addr | output | AW | Address of the requested payload byte |
| rd_ready | input | 1 | Memory returns rd_data for rd_addr in this cycle |
| rd_data | input | 8 | Payload byte from memory |
| out_ready | input | 1 | Downstream takes the presented symbol at this edge |
| out_ctrl | output | 1 | The presented symbol is a control symbol |
| out_data | output | 8 | Presented data byte or control code |

## Verification
The assertions check, on every cycle, the per-cycle rules:
- filler is shown while idle and during a read stall;
- the read address stays stable across a stall;
- the upper address bits stay fixed while the low bits step by one inside the ring mask;
- a read request never appears while the output is backpressured;
- an accepted descriptor leads to a header marker on the next cycle;
- every error pulse follows an acceptance.

Only the bench scenarios can show that whole frames come out in the right order with the right bytes. The same holds for the following, which are all properties of a complete frame rather than of a single cycle:
- no payload byte is lost or repeated under stalls;
- back-to-back frames join without a gap;
- an empty payload still carries its markers;
- an oversized descriptor produces no symbols at all.

// File: rtl/tx_gather_pkg.sv
package tx_gather_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HMARK,
    ST_HDR,
    ST_PMARK,
    ST_PAY
  } tx_state_e;

  localparam logic [7:0] SYM_FILL = 8'h1C;
  localparam logic [7:0] SYM_HDR  = 8'h3C;
  localparam logic [7:0] SYM_PAY  = 8'h5C;
endpackage

// File: rtl/tx_desc_check.sv
module tx_desc_check #(
  parameter int LW = 12,
  parameter int EW = 5
) (
  input  logic [LW-1:0] len,
  input  logic [EW-1:0] ring_log2,
  output logic          fits
);
  // A payload fits when its length does not exceed the ring size 2^k.
  function automatic logic len_fits(input logic [LW-1:0] l, input logic [EW-1:0] k);
    logic [LW:0] size;
    if (32'(k) >= LW) begin
      return 1'b1;
    end
    size = (LW+1)'(1) << k;
    return ({1'b0, l} <= size);
  endfunction

  assign fits = len_fits(len, ring_log2);
endmodule

// File: rtl/tx_ring_addr.sv
module tx_ring_addr #(
  parameter int AW = 16,
  parameter int LW = 12,
  parameter int EW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [LW-1:0] load_len,
  input  logic [EW-1:0] load_log2,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [LW-1:0] rem_len,
  output logic [AW-1:0] ring_mask
);
  // Mask of the low bits that count inside the ring; all ones when k >= AW.
  function automatic logic [AW-1:0] mask_of(input logic [EW-1:0] k);
    logic [AW:0] w;
    w = (({{AW{1'b0}}, 1'b1}) << k) - 1'b1;
    return w[AW-1:0];
  endfunction

  // Next address: upper bits held, low bits incremented modulo the ring size.
  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] a, input logic [AW-1:0] m);
    return (a & ~m) | ((a + 1'b1) & m);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr  <= '0;
      rem_len   <= '0;
      ring_mask <= '0;
    end else if (load) begin
      cur_addr  <= load_addr;
      rem_len   <= load_len;
      ring_mask <= mask_of(load_log2);
    end else if (step) begin
      cur_addr  <= wrap_inc(cur_addr, ring_mask);
      rem_len   <= rem_len - 1'b1;
    end
  end
endmodule

// File: rtl/tx_gather.sv
module tx_gather
  import tx_gather_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 12,
  parameter int EW = 5,
  parameter int HB = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            desc_valid,
  output logic            desc_ready,
  input  logic [HB*8-1:0] desc_hdr,
  input  logic [AW-1:0]   desc_addr,
  input  logic [LW-1:0]   desc_len,
  input  logic [EW-1:0]   desc_ring_log2,
  output logic            desc_err,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  input  logic            rd_ready,
  input  logic [7:0]      rd_data,
  input  logic            out_ready,
  output logic            out_ctrl,
  output logic [7:0]      out_data
);
  localparam int HIW = (HB > 1) ? $clog2(HB) : 1;

  tx_state_e        state_q;
  logic [HB*8-1:0]  hdr_q;
  logic [HIW-1:0]   hidx_q;
  logic             err_q;

  // Named internal events, also observed by the bound checker.
  logic             st_idle, st_pay;
  logic             len_ok, accept, accept_ok, reject;
  logic             byte_fire, pay_last, last_fire;
  logic [LW-1:0]    rem_len;
  logic [AW-1:0]    ring_mask;

  tx_desc_check #(.LW(LW), .EW(EW)) u_check (
    .len       (desc_len),
    .ring_log2 (desc_ring_log2),
    .fits      (len_ok)
  );

  tx_ring_addr #(.AW(AW), .LW(LW), .EW(EW)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .load      (accept_ok),
    .load_addr (desc_addr),
    .load_len  (desc_len),
    .load_log2 (desc_ring_log2),
    .step      (byte_fire),
    .cur_addr  (rd_addr),
    .rem_len   (rem_len),
    .ring_mask (ring_mask)
  );

  assign st_idle    = (state_q == ST_IDLE);
  assign st_pay     = (state_q == ST_PAY);
  assign rd_req     = st_pay && out_ready;
  assign byte_fire  = rd_req && rd_ready;
  assign pay_last   = (rem_len == LW'(1));
  assign last_fire  = byte_fire && pay_last;
  assign desc_ready = st_idle || last_fire;
  assign accept     = desc_valid && desc_ready;
  assign accept_ok  = accept && len_ok;
  assign reject     = accept && !len_ok;
  assign desc_err   = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      hidx_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= reject;
      if (accept_ok) hdr_q <= desc_hdr;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_ok) state_q <= ST_HMARK;
        end
        ST_HMARK: begin
          if (out_ready) begin
            state_q <= ST_HDR;
            hidx_q  <= '0;
          end
        end
        ST_HDR: begin
          if (out_ready) begin
            if (hidx_q == HIW'(HB-1)) state_q <= ST_PMARK;
            else hidx_q <= hidx_q + 1'b1;
          end
        end
        ST_PMARK: begin
          if (out_ready) state_q <= (rem_len == '0) ? ST_IDLE : ST_PAY;
        end
        ST_PAY: begin
          if (last_fire) state_q <= accept_ok ? ST_HMARK : ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    out_ctrl = 1'b1;
    out_data = SYM_FILL;
    unique case (state_q)
      ST_HMARK: out_data = SYM_HDR;
      ST_HDR: begin
        out_ctrl = 1'b0;
        out_data = hdr_q[8*hidx_q +: 8];
      end
      ST_PMARK: out_data = SYM_PAY;
      ST_PAY: begin
        if (byte_fire) begin
          out_ctrl = 1'b0;
          out_data = rd_data;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tx_gather_chk.sv
module tx_gather_chk
  import tx_gather_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          desc_valid,
  input logic          desc_ready,
  input logic          desc_err,
  input logic          rd_req,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          out_ready,
  input logic          out_ctrl,
  input logic [7:0]    out_data,
  input logic          st_idle,
  input logic          st_pay,
  input logic          accept_ok,
  input logic          byte_fire,
  input logic          pay_last,
  input logic [AW-1:0] ring_mask
);
  p_idle_fill_r1: assert property (@(posedge clk) disable iff (rst)
    st_idle |-> (out_ctrl && out_data == SYM_FILL && !rd_req));

  p_ring_high_r3: assert property (@(posedge clk) disable iff (rst)
    (byte_fire && !pay_last) |=> ((rd_addr & ~ring_mask) == ($past(rd_addr) & ~ring_mask)));

  p_ring_low_r3: assert property (@(posedge clk) disable iff (rst)
    (byte_fire && !pay_last) |=> ((rd_addr & ring_mask) == (($past(rd_addr) + 1'b1) & ring_mask)));

  p_stall_fill_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ready) |-> (out_ctrl && out_data == SYM_FILL));

  p_stall_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ready) |=> $stable(rd_addr));

  p_no_read_r5: assert property (@(posedge clk) disable iff (rst)
    !out_ready |-> !rd_req);

  p_hold_sym_r5: assert property (@(posedge clk) disable iff (rst)
    (!out_ready && !st_idle && !st_pay) |=> ($stable(out_ctrl) && $stable(out_data)));

  p_start_mark_r6: assert property (@(posedge clk) disable iff (rst)
    accept_ok |=> (out_ctrl && out_data == SYM_HDR));

  p_err_after_take_r8: assert property (@(posedge clk) disable iff (rst)
    desc_err |-> $past(desc_valid && desc_ready));
endmodule

bind tx_gather tx_gather_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .desc_valid (desc_valid),
  .desc_ready (desc_ready),
  .desc_err   (desc_err),
  .rd_req     (rd_req),
  .rd_ready   (rd_ready),
  .rd_addr    (rd_addr),
  .out_ready  (out_ready),
  .out_ctrl   (out_ctrl),
  .out_data   (out_data),
  .st_idle    (st_idle),
  .st_pay     (st_pay),
  .accept_ok  (accept_ok),
  .byte_fire  (byte_fire),
  .pay_last   (pay_last),
  .ring_mask  (ring_mask)
);

// File: tb/sim_tx_gather.sv
`timescale 1ns/1ps
module sim_tx_gather;
  localparam int AW = 16, LW = 12, EW = 5, HB = 4;
  localparam logic [7:0] C_FILL = 8'h1C, C_HDR = 8'h3C, C_PAY = 8'h5C;
  localparam logic [8:0] FILL9 = {1'b1, 8'h1C};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst = 1'b1;
  logic            desc_valid = 1'b0, desc_ready;
  logic [HB*8-1:0] desc_hdr = '0;
  logic [AW-1:0]   desc_addr = '0;
  logic [LW-1:0]   desc_len = '0;
  logic [EW-1:0]   desc_ring_log2 = '0;
  logic            desc_err, rd_req;
  logic [AW-1:0]   rd_addr;
  logic            rd_ready = 1'b1;
  logic [7:0]      rd_data;
  logic            out_ready = 1'b1;
  logic            out_ctrl;
  logic [7:0]      out_data;

  tx_gather #(.AW(AW), .LW(LW), .EW(EW), .HB(HB)) u0 (
    .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_hdr(desc_hdr), .desc_addr(desc_addr), .desc_len(desc_len),
    .desc_ring_log2(desc_ring_log2), .desc_err(desc_err), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .out_ready(out_ready), .out_ctrl(out_ctrl), .out_data(out_data)
  );

  function automatic logic [7:0] mem_fn(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]};
  endfunction
  assign rd_data = mem_fn(rd_addr);

  int n_chk = 0, n_bad = 0, err_seen = 0;
  bit stall_mode = 0, bp_mode = 0, bp_force = 0;
  logic [8:0]    cap[$];
  logic [AW-1:0] rdlog[$];

  // Flow-control drivers, changed only at the falling edge.
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      rd_ready  = stall_mode ? cyc[0] : 1'b1;
      out_ready = bp_force ? 1'b0 : (bp_mode ? (cyc % 3 != 0) : 1'b1);
    end
  end

  // Record what will transfer at the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && out_ready) cap.push_back({out_ctrl, out_data});
      if (!rst && rd_req && rd_ready) rdlog.push_back(rd_addr);
      if (!rst && desc_err) err_seen++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Ring wrap restated with integer division.
  function automatic int wrap_at(input int a, input int k, input int i);
    int sz = 1 << k;
    return (a - (a % sz)) + (((a % sz) + i) % sz);
  endfunction

  task automatic build(inout logic [8:0] q[$], input logic [31:0] hdr,
                       input int a, input int len, input int k);
    q.push_back({1'b1, C_HDR});
    for (int i = 0; i < HB; i++) q.push_back({1'b0, hdr[8*i +: 8]});
    q.push_back({1'b1, C_PAY});
    for (int i = 0; i < len; i++) q.push_back({1'b0, mem_fn(AW'(wrap_at(a, k, i)))});
  endtask

  task automatic clear_logs();
    cap.delete();
    rdlog.delete();
    err_seen = 0;
  endtask

  task automatic send(input logic [31:0] hdr, input int a, input int len, input int k);
    bit took;
    @(negedge clk);
    desc_valid = 1'b1;
    desc_hdr = hdr;
    desc_addr = AW'(a);
    desc_len = LW'(len);
    desc_ring_log2 = EW'(k);
    do begin
      #1;
      took = desc_ready;
      @(negedge clk);
    end while (!took);
    desc_valid = 1'b0;
  endtask

  task automatic cmp_stream(input string req, input logic [8:0] e[$]);
    logic [8:0] f[$];
    int bad = -1;
    foreach (cap[i]) if (cap[i] != FILL9) f.push_back(cap[i]);
    chk(f.size() == e.size(), req, "symbol count", f.size(), e.size());
    if (f.size() == e.size()) begin
      foreach (e[i]) if (bad < 0 && f[i] !== e[i]) bad = i;
      chk(bad < 0, req, "symbol stream", bad < 0 ? 0 : f[bad], bad < 0 ? 0 : e[bad]);
    end
  endtask

  task automatic cmp_addrs(input string req, input int a, input int len, input int k);
    int bad = -1;
    chk(rdlog.size() == len, req, "read count", rdlog.size(), len);
    if (rdlog.size() == len) begin
      for (int i = 0; i < len; i++) if (bad < 0 && rdlog[i] != AW'(wrap_at(a, k, i))) bad = i;
      chk(bad < 0, req, "read address", bad < 0 ? 0 : rdlog[bad],
          bad < 0 ? 0 : wrap_at(a, k, bad));
    end
  endtask

  task automatic t_reset();
    #1;
    chk(out_ctrl && out_data == C_FILL, "R1", "idle symbol", {out_ctrl, out_data}, {1'b1, C_FILL});
    chk(desc_ready && !rd_req && !desc_err, "R1", "idle handshake",
        {desc_ready, rd_req, desc_err}, 3'b100);
  endtask

  task automatic t_basic();
    logic [8:0] e[$];
    clear_logs();
    send(32'hA1B2C3D4, 16'h1230, 5, 8);
    repeat (20) @(negedge clk);
    build(e, 32'hA1B2C3D4, 16'h1230, 5, 8);
    cmp_stream("R2", e);
    cmp_addrs("R3", 16'h1230, 5, 8);
    #1;
    chk(out_ctrl && out_data == C_FILL, "R1", "filler after frame", {out_ctrl, out_data}, {1'b1, C_FILL});
  endtask

  task automatic t_wrap();
    logic [8:0] e[$];
    clear_logs();
    send(32'h01020304, 16'h12FD, 6, 8);
    repeat (20) @(negedge clk);
    build(e, 32'h01020304, 16'h12FD, 6, 8);
    cmp_stream("R3", e);
    cmp_addrs("R3", 16'h12FD, 6, 8);
    clear_logs();
    send(32'h55667788, 16'hFFFE, 4, 16);
    repeat (20) @(negedge clk);
    cmp_addrs("R3", 16'hFFFE, 4, 16);
  endtask

  task automatic t_stall();
    logic [8:0] e[$];
    int p = -1, got = 0, fills = 0;
    clear_logs();
    stall_mode = 1;
    send(32'hDEADBEEF, 16'h0407, 6, 3);
    repeat (40) @(negedge clk);
    stall_mode = 0;
    build(e, 32'hDEADBEEF, 16'h0407, 6, 3);
    cmp_stream("R4", e);
    cmp_addrs("R4", 16'h0407, 6, 3);
    foreach (cap[i]) if (p < 0 && cap[i] == {1'b1, C_PAY}) p = i;
    if (p >= 0)
      for (int i = p + 1; i < cap.size() && got < 6; i++) begin
        if (cap[i] == FILL9) fills++;
        else got++;
      end
    chk(fills > 0, "R4", "filler inside payload", fills, 1);
  endtask

  task automatic t_backpressure();
    logic [8:0] e[$];
    logic [8:0] first;
    clear_logs();
    bp_force = 1;
    send(32'h11223344, 16'h0800, 3, 4);
    #1;
    first = {out_ctrl, out_data};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk({out_ctrl, out_data} == first && first == {1'b1, C_HDR} && !rd_req,
          "R5", "held marker", {out_ctrl, out_data}, {1'b1, C_HDR});
    end
    bp_force = 0;
    bp_mode = 1;
    repeat (30) @(negedge clk);
    bp_mode = 0;
    build(e, 32'h11223344, 16'h0800, 3, 4);
    cmp_stream("R5", e);
  endtask

  task automatic t_back_to_back();
    logic [8:0] e[$];
    int second = -1, n = 0;
    clear_logs();
    send(32'hCAFEF00D, 16'h2000, 4, 8);
    send(32'h0BADC0DE, 16'h3000, 3, 8);
    repeat (20) @(negedge clk);
    build(e, 32'hCAFEF00D, 16'h2000, 4, 8);
    build(e, 32'h0BADC0DE, 16'h3000, 3, 8);
    cmp_stream("R6", e);
    foreach (cap[i]) if (cap[i] == {1'b1, C_HDR}) begin
      n++;
      if (n == 2) second = i;
    end
    chk(second > 0 && cap[second-1][8] == 1'b0, "R6", "no gap before second frame",
        second > 0 ? cap[second-1] : 0, 0);
  endtask

  task automatic t_zero_len();
    logic [8:0] e[$];
    clear_logs();
    send(32'h99AABBCC, 16'h4000, 0, 2);
    repeat (12) @(negedge clk);
    build(e, 32'h99AABBCC, 16'h4000, 0, 2);
    cmp_stream("R7", e);
    chk(rdlog.size() == 0, "R7", "no reads", rdlog.size(), 0);
    #1;
    chk(desc_ready && out_ctrl && out_data == C_FILL, "R7", "back to idle",
        {desc_ready, out_ctrl, out_data}, {2'b11, C_FILL});
  endtask

  task automatic t_reject();
    logic [8:0] e[$];
    clear_logs();
    send(32'h12345678, 16'h5000, 300, 8);
    repeat (6) @(negedge clk);
    chk(err_seen == 1, "R8", "error pulse width", err_seen, 1);
    chk(cap.size() > 0 && rdlog.size() == 0, "R8", "no reads on reject", rdlog.size(), 0);
    cmp_stream("R8", e);
    clear_logs();
    send(32'h12345678, 16'h5000, 3, 1);
    repeat (6) @(negedge clk);
    chk(err_seen == 1, "R8", "small ring reject", err_seen, 1);
    clear_logs();
    send(32'h87654321, 16'h5100, 256, 8);
    repeat (280) @(negedge clk);
    chk(err_seen == 0, "R8", "exact fit no error", err_seen, 0);
    build(e, 32'h87654321, 16'h5100, 256, 8);
    cmp_stream("R8", e);
  endtask

  initial begin
    bit timed_out = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    fork
      begin
        t_reset();
        t_basic();
        t_wrap();
        t_stall();
        t_backpressure();
        t_back_to_back();
        t_zero_len();
        t_reject();
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) chk(1'b0, "ALL", "watchdog expired", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule